// File: doc/BRIEF.md
# Serial Bit Clock Source Selector

This block runs on the master clock and decides, frame by frame, where the serial bit clock of an audio input port comes from. When the serial clock pin toggles, each of its rising edges is passed on as a one-cycle bit strobe in the master clock domain. When the pin stays quiet for a whole frame-clock period, the block makes its own bit clock by dividing the master clock.

To build that internal clock it counts master clock cycles from one frame-clock rise to the next. It accepts only 256, 384 or 512. The divisor is chosen from that ratio and from a word-length select, so that every frame-clock half holds a whole number of bit strobes. The divider restarts on every frame-clock edge, which keeps the generated strobes locked to the frame clock. Downstream logic samples serial data on `bitStrobe`. It can read `extMode` to learn which source is active and `ratioValid` to learn whether the internal clock is running.

Top module: `bitclk_source`

## Requirements
- R1: During reset and directly after its release, `extMode`, `ratioValid` and `bitStrobe` are all 0.
- R2: The ratio is the number of MCLK cycles between two successive synchronized LRCLK rising edges. A rise that closes a period of exactly 256, 384 or 512 cycles sets `ratioValid`. The first rise after reset only starts a measurement. `ratioValid` changes only at an LRCLK rise or at counter saturation.
- R3: A period of any other length clears `ratioValid` at the rise that closes it. So does LRCLK staying without a rise for 2^CNT_W-1 cycles. While `ratioValid` is 0 and the block is in internal mode, no bit strobe is produced.
- R4: With `wordSel`=0 (16-bit words), a ratio of 256 gives a strobe every 8 MCLK cycles and 16 strobes per LRCLK half. A ratio of 512 gives a strobe every 16 cycles and again 16 per half.
- R5: With `wordSel`=1 (18-bit words), a ratio of 256 gives a strobe every 4 cycles and 32 per half. A ratio of 512 gives a strobe every 8 cycles and 32 per half.
- R6: A ratio of 384 gives a strobe every 8 cycles and 24 per half, for either value of `wordSel`.
- R7: The internal divider restarts on every LRCLK edge of either polarity. Suppose LRCLK changes just after MCLK rising edge n and the divisor is D. Then the k-th internal strobe (k = 1..B) is high in the cycle after MCLK edge n+3+k*D. The last one falls in the cycle in which the following LRCLK edge is seen.
- R8: Any SCLK edge selects external mode. An SCLK rise applied just after MCLK edge n gives exactly one `bitStrobe` in the cycle after edge n+3, with `extMode` 1 from that edge onward. No internal strobes appear in external mode.
- R9: The block goes back to internal mode at the first LRCLK rise that closes a full rise-to-rise period with no SCLK edge in it. A period that held at least one SCLK edge keeps external mode.
- R10: `bitStrobe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (MCLK); all logic is clocked on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | External serial bit clock, asynchronous to clk |
| lrclkIn | input | 1 | Frame (left/right) clock, asynchronous to clk |
| wordSel | input | 1 | Word length: 0 = 16-bit words, 1 = 18-bit words |
| bitStrobe | output | 1 | One-cycle pulse per serial bit clock rising edge |
| extMode | output | 1 | 1 while the external serial clock is the source |
| ratioValid | output | 1 | 1 while the measured MCLK/LRCLK ratio is a supported value |

## Verification
The last internal strobe of each LRCLK half and the divider restart on the next LRCLK edge fall in the same cycle. A design that favours either one ends up one strobe short or one strobe late. Every internal half that is scored provokes this collision, across all six ratio and word-length pairs. A scoreboard then judges it by expecting exactly B strobes at the computed cycle stamps, the final one at the LRCLK edge plus the three-cycle pipeline. A second collision happens on return to internal mode, where the mode change and a divider tick land on the same LRCLK rise. It is covered by scoring the frames that follow the timeout.

// File: rtl/bitclk_source_pkg.sv
`timescale 1ns/1ps
package bitclk_source_pkg;

  // Supported MCLK/LRCLK ratio classes
  typedef enum logic [1:0] {
    RT_LO  = 2'd0,
    RT_MID = 2'd1,
    RT_HI  = 2'd2
  } ratioE;

  // Edge events found by the datapath, consumed by the control
  typedef struct packed {
    logic sclkRise;
    logic sclkEdge;
    logic lrRise;
    logic lrEdge;
    logic perSat;
  } edgeT;

  // Control decisions handed back to the datapath
  typedef struct packed {
    logic  extNxt;
    logic  ratioOk;
    ratioE ratio;
  } ctrlT;

endpackage

// File: rtl/bitclk_source_dp.sv
`timescale 1ns/1ps
module bitclk_source_dp
  import bitclk_source_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int RATIO_LO    = 256,
  parameter int RATIO_MID   = 384,
  parameter int RATIO_HI    = 512,
  parameter int SLOTS_SHORT = 16,
  parameter int SLOTS_LONG  = 32,
  parameter int SLOTS_MID   = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             lrclkIn,
  input  logic             wordSel,
  input  ctrlT             ctrl,
  output edgeT             edges,
  output logic [CNT_W-1:0] perLen,
  output logic             bitStrobe
);

  // Divisors: MCLK cycles per bit slot within one LRCLK half
  localparam int DIV_LO_S = RATIO_LO  / (2 * SLOTS_SHORT);
  localparam int DIV_LO_L = RATIO_LO  / (2 * SLOTS_LONG);
  localparam int DIV_MID  = RATIO_MID / (2 * SLOTS_MID);
  localparam int DIV_HI_S = RATIO_HI  / (2 * SLOTS_SHORT);
  localparam int DIV_HI_L = RATIO_HI  / (2 * SLOTS_LONG);
  localparam int DIV_W    = $clog2(RATIO_HI) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Two-or-more flop synchronizers plus one history flop per input
  logic [SYNC_STAGES-1:0] sclkPipe, lrPipe;
  logic sclkPrev, lrPrev, sclkSync, lrSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      lrPipe   <= '0;
      sclkPrev <= 1'b0;
      lrPrev   <= 1'b0;
    end else begin
      for (int s = SYNC_STAGES - 1; s > 0; s--) begin
        sclkPipe[s] <= sclkPipe[s-1];
        lrPipe[s]   <= lrPipe[s-1];
      end
      sclkPipe[0] <= sclkIn;
      lrPipe[0]   <= lrclkIn;
      sclkPrev    <= sclkSync;
      lrPrev      <= lrSync;
    end
  end

  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign lrSync   = lrPipe[SYNC_STAGES-1];

  assign edges.sclkRise = sclkSync & ~sclkPrev;
  assign edges.sclkEdge = sclkSync ^ sclkPrev;
  assign edges.lrRise   = lrSync & ~lrPrev;
  assign edges.lrEdge   = lrSync ^ lrPrev;

  // Rise-to-rise period counter, saturating so a stopped LRCLK never aliases
  logic [CNT_W-1:0] perCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                perCnt <= '0;
    else if (edges.lrRise)    perCnt <= CNT_W'(1);
    else if (perCnt != CNT_MAX) perCnt <= perCnt + 1'b1;
  end

  assign perLen       = perCnt;
  assign edges.perSat = (perCnt == CNT_MAX);

  // Internal bit divider, re-phased on each LRCLK edge
  logic [DIV_W-1:0] divCnt, divLast;
  logic intTick;

  always_comb begin
    unique case (ctrl.ratio)
      RT_MID:  divLast = DIV_W'(DIV_MID - 1);
      RT_HI:   divLast = wordSel ? DIV_W'(DIV_HI_L - 1) : DIV_W'(DIV_HI_S - 1);
      default: divLast = wordSel ? DIV_W'(DIV_LO_L - 1) : DIV_W'(DIV_LO_S - 1);
    endcase
  end

  assign intTick = (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         divCnt <= '0;
    else if (edges.lrEdge || intTick)  divCnt <= '0;
    else                               divCnt <= divCnt + 1'b1;
  end

  // Source mux and output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitStrobe <= 1'b0;
    else       bitStrobe <= ctrl.extNxt ? edges.sclkRise : (ctrl.ratioOk & intTick);
  end

endmodule

// File: rtl/bitclk_source_ctrl.sv
`timescale 1ns/1ps
module bitclk_source_ctrl
  import bitclk_source_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int RATIO_LO  = 256,
  parameter int RATIO_MID = 384,
  parameter int RATIO_HI  = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  edgeT             edges,
  input  logic [CNT_W-1:0] perLen,
  output ctrlT             ctrl,
  output logic             extMode,
  output logic             ratioValid
);

  logic  armed, sawSclk, extNxt, lenOk;
  ratioE ratio, ratioNxt;
  logic  unusedBits;

  assign unusedBits = ^{edges.sclkRise, edges.lrEdge};

  // Ratio classification of the period just closed
  always_comb begin
    lenOk    = 1'b1;
    ratioNxt = ratio;
    if (perLen == CNT_W'(RATIO_LO))       ratioNxt = RT_LO;
    else if (perLen == CNT_W'(RATIO_MID)) ratioNxt = RT_MID;
    else if (perLen == CNT_W'(RATIO_HI))  ratioNxt = RT_HI;
    else                                  lenOk = 1'b0;
  end

  // Source selection: any SCLK edge wins, a silent frame falls back
  always_comb begin
    if (edges.sclkEdge)                    extNxt = 1'b1;
    else if (edges.lrRise && !sawSclk)     extNxt = 1'b0;
    else                                   extNxt = extMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      sawSclk    <= 1'b0;
      extMode    <= 1'b0;
      ratioValid <= 1'b0;
      ratio      <= RT_LO;
    end else begin
      extMode <= extNxt;
      if (edges.lrRise)        sawSclk <= edges.sclkEdge;
      else if (edges.sclkEdge) sawSclk <= 1'b1;
      if (edges.lrRise) begin
        armed <= 1'b1;
        if (armed && lenOk) begin
          ratioValid <= 1'b1;
          ratio      <= ratioNxt;
        end else begin
          ratioValid <= 1'b0;
        end
      end else if (edges.perSat) begin
        ratioValid <= 1'b0;
      end
    end
  end

  assign ctrl.extNxt  = extNxt;
  assign ctrl.ratioOk = ratioValid;
  assign ctrl.ratio   = ratio;

endmodule

// File: rtl/bitclk_source.sv
`timescale 1ns/1ps
module bitclk_source
  import bitclk_source_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int RATIO_LO    = 256,
  parameter int RATIO_MID   = 384,
  parameter int RATIO_HI    = 512,
  parameter int SLOTS_SHORT = 16,
  parameter int SLOTS_LONG  = 32,
  parameter int SLOTS_MID   = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic lrclkIn,
  input  logic wordSel,
  output logic bitStrobe,
  output logic extMode,
  output logic ratioValid
);

  edgeT             edges;
  ctrlT             ctrlBus;
  logic [CNT_W-1:0] perLen;

  bitclk_source_dp #(
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W),
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI),
    .SLOTS_SHORT(SLOTS_SHORT), .SLOTS_LONG(SLOTS_LONG), .SLOTS_MID(SLOTS_MID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrclkIn(lrclkIn),
    .wordSel(wordSel), .ctrl(ctrlBus), .edges(edges), .perLen(perLen),
    .bitStrobe(bitStrobe)
  );

  bitclk_source_ctrl #(
    .CNT_W(CNT_W), .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .edges(edges), .perLen(perLen),
    .ctrl(ctrlBus), .extMode(extMode), .ratioValid(ratioValid)
  );

endmodule

// File: rtl/bitclk_source_chk.sv
`timescale 1ns/1ps
module bitclk_source_chk (
  input logic clk,
  input logic rstN,
  input logic sclkRise,
  input logic sclkEdge,
  input logic lrRise,
  input logic perSat,
  input logic extNxt,
  input logic extMode,
  input logic ratioValid,
  input logic bitStrobe
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!extMode && !ratioValid && !bitStrobe));

  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!lrRise && !perSat) |=> $stable(ratioValid));

  p_sat_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (perSat && !lrRise) |=> !ratioValid);

  p_idle_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ratioValid && !extNxt) |=> !bitStrobe);

  p_ext_on_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclkEdge |=> extMode);

  p_rise_passes_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclkRise |=> bitStrobe);

  p_exit_at_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extMode) |-> $past(lrRise));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

endmodule

bind bitclk_source bitclk_source_chk u_chk (
  .clk(clk), .rstN(rstN),
  .sclkRise(edges.sclkRise), .sclkEdge(edges.sclkEdge),
  .lrRise(edges.lrRise), .perSat(edges.perSat),
  .extNxt(ctrlBus.extNxt), .extMode(extMode),
  .ratioValid(ratioValid), .bitStrobe(bitStrobe)
);

// File: tb/tb_bitclk_source.sv
`timescale 1ns/1ps
module tb_bitclk_source;

  localparam int SCLK_HALF = 3;

  logic clk = 1'b0, rstN = 1'b0, sclkIn = 1'b0, lrclkIn = 1'b0, wordSel = 1'b0;
  logic bitStrobe, extMode, ratioValid;

  int    cyc = 0, nChk = 0, nFail = 0, sclkPh = 0;
  int    lo = 0, hi = 0;
  int    expQ[$];
  string curTag = "R1";
  logic  prevS = 1'b0;
  bit    done = 1'b0;

  bitclk_source dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrclkIn(lrclkIn),
    .wordSel(wordSel), .bitStrobe(bitStrobe), .extMode(extMode),
    .ratioValid(ratioValid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected strobe cycles and compares
  always @(negedge clk) begin
    if (rstN) begin
      if (bitStrobe) begin
        chk("R10", int'(prevS), 0);
        if (cyc > lo && cyc <= hi) begin
          if (expQ.size() == 0) chk(curTag, cyc, -1);
          else                  chk(curTag, cyc, expQ.pop_front());
        end
      end
      prevS = bitStrobe;
    end
  end

  // Driver: one call drives whole LRCLK periods and pushes expected strobes
  task automatic run(input int ratio, input int periods, input bit w,
                     input bit useSclk, input bit intExp, input bit score,
                     input string tag);
    int   half  = ratio / 2;
    int   slots = (ratio == 384) ? 24 : (w ? 32 : 16);
    int   d     = half / slots;
    int   last  = 0;
    logic nxt;
    for (int p = 0; p < periods; p++) begin
      for (int i = 0; i < ratio; i++) begin
        @(negedge clk);
        wordSel = w;
        lrclkIn = (i < half);
        if (score) begin
          curTag = tag;
          if (p == 0 && i == 0) begin
            lo = cyc + 3;
            hi = 32'h7fffffff;
          end
          if (intExp && (i == 0 || i == half))
            for (int k = 1; k <= slots; k++) expQ.push_back(cyc + 3 + k * d);
        end
        if (useSclk) begin
          sclkPh++;
          nxt = ((sclkPh / SCLK_HALF) % 2) == 1;
          if (score && nxt && !sclkIn && (cyc + 3 > lo)) expQ.push_back(cyc + 3);
          sclkIn = nxt;
        end
        last = cyc;
      end
    end
    if (score) hi = last + 4;
  endtask

  task automatic flush(input string tag);
    repeat (6) @(negedge clk);
    chk(tag, expQ.size(), 0);
    expQ.delete();
    hi = 0;
  endtask

  task automatic phase(input int ratio, input bit w, input string tag);
    run(ratio, 2, w, 1'b0, 1'b0, 1'b0, tag);
    run(ratio, 2, w, 1'b0, 1'b1, 1'b1, tag);
    flush(tag);
    chk(tag, int'(extMode), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'(bitStrobe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'(extMode), 0);
    chk("R1", int'(ratioValid), 0);
    chk("R1", int'(bitStrobe), 0);

    // First rise only arms the measurement
    run(256, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    chk("R2", int'(ratioValid), 0);
    run(256, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    chk("R2", int'(ratioValid), 1);
    run(256, 2, 1'b0, 1'b0, 1'b1, 1'b1, "R4 R7");
    flush("R4 R7");

    phase(256, 1'b1, "R5 R7");
    phase(384, 1'b0, "R6");
    phase(384, 1'b1, "R6");
    phase(512, 1'b0, "R4");
    phase(512, 1'b1, "R5");

    // Unsupported ratio
    run(300, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    chk("R3", int'(ratioValid), 0);
    run(300, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    flush("R3");

    // External serial clock
    run(256, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    chk("R8", int'(extMode), 1);
    run(256, 2, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    flush("R8");
    chk("R8", int'(extMode), 1);

    // Timeout back to internal
    run(256, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    chk("R9", int'(extMode), 1);
    run(256, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    chk("R9", int'(extMode), 0);
    run(256, 2, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    flush("R9");

    // Stopped LRCLK saturates the period counter
    chk("R3", int'(ratioValid), 1);
    repeat (1100) @(negedge clk);
    chk("R3", int'(ratioValid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule